// File: doc/BRIEF.md
# SPI Command Decoder with Register Access

This block sits behind the serial port of a data-converter style peripheral. It receives bytes from an SPI master with data clocked in on the falling SCLK edge. Single-byte control opcodes become one-cycle pulses for the converter core: wake-up, standby, reset, start/resync, stop, offset calibration and a single on-demand data read. It also keeps a continuous-readout mode flag for the conversion data path.

Two-byte register commands give software access to a 32-entry, 8-bit register file held in the block. The first byte holds the operation and a start address. The second byte holds a count. The data bytes that follow are then streamed, out on MISO for a read or in from MOSI for a write. SCLK, chip select and MOSI are brought into the system clock through two-flop synchronisers, so SCLK must run well below the system clock (at least four system cycles per SCLK phase).

Top module: `spi_cmd_front`

## Requirements
- R1: The bytes 02h, 04h, 06h, 08h, 0Ah and 1Ah produce a one-cycle pulse on wake_p, stby_p, reset_p, start_p, stop_p and ocal_p respectively. The pulse is decided from the upper seven bits at the seventh falling SCLK edge of the byte, so bit 0 is not examined (03h also pulses wake_p). At most one pulse output is high in any cycle.
- R2: Byte 12h produces a one-cycle rdata_p pulse, also decided at the seventh falling edge.
- R3: cont_mode is 1 after rst. At the eighth falling edge, byte 10h sets it and byte 11h clears it. The reset opcode 06h also sets it.
- R4: When cont_mode is 0, a first byte 001a_aaaa (read) or 010a_aaaa (write) is taken at its eighth edge, with a_aaaa as the start address. The low five bits of the next byte give a count c. count+1 registers are then transferred, and the address increments after each one and wraps from 31 to 0.
- R5: For a read, each register is driven on MISO MSB first. The bit for position 7-k is present before falling edge k+1 of its byte. miso_oe is 1 only during the read data bytes and returns to 0 after the last one.
- R6: For a write, each following byte is captured from MOSI at its eighth edge and stored at the current address.
- R7: Chip select going high at any time abandons a partial command, clears the bit count and drops miso_oe. A data byte that is not complete is not stored.
- R8: A byte that matches none of the opcodes in R1 to R4 changes no output and no register.
- R9: While cont_mode is 1, register read and write first bytes are ignored, and the bytes after them are decoded as new commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for the MISO pad |
| cont_mode | output | 1 | Continuous readout mode flag |
| wake_p | output | 1 | Wake-up pulse |
| stby_p | output | 1 | Standby pulse |
| reset_p | output | 1 | Device reset pulse |
| start_p | output | 1 | Start/resync conversions pulse |
| stop_p | output | 1 | Stop conversions pulse |
| ocal_p | output | 1 | Offset calibration pulse |
| rdata_p | output | 1 | Single data read request pulse |

## Verification
A table drives every control opcode, copies that differ only in bit 0, and unused bytes through the decoder. It checks both that the right pulse alone fires and that it has already fired before the eighth edge, which separates seventh-edge decoding from full-byte decoding. Mode changes are sampled between the seventh and eighth edges to tell them apart from control pulses. Register tests use offset starts, multi-byte bursts and a burst that crosses address 31, which expose errors in the count, the increment and the wrap. Chip select is raised in mid-byte during a write, during a read and during a control opcode, and each case shows whether the bit counter and state really restart.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int NCTRL = 7;
  localparam int CP_WAKE  = 0;
  localparam int CP_STBY  = 1;
  localparam int CP_RST   = 2;
  localparam int CP_START = 3;
  localparam int CP_STOP  = 4;
  localparam int CP_OCAL  = 5;
  localparam int CP_RDATA = 6;

  localparam logic [7:0] OP_WAKE  = 8'h02;
  localparam logic [7:0] OP_STBY  = 8'h04;
  localparam logic [7:0] OP_RST   = 8'h06;
  localparam logic [7:0] OP_START = 8'h08;
  localparam logic [7:0] OP_STOP  = 8'h0A;
  localparam logic [7:0] OP_OCAL  = 8'h1A;
  localparam logic [7:0] OP_RDATA = 8'h12;
  localparam logic [7:0] OP_CONT_ON  = 8'h10;
  localparam logic [7:0] OP_CONT_OFF = 8'h11;
  localparam logic [2:0] GRP_RREG = 3'b001;
  localparam logic [2:0] GRP_WREG = 3'b010;

  localparam int CNT_W = 5;

  typedef enum logic [1:0] {ST_CMD, ST_ARG, ST_RD, ST_WR} scd_state_t;

  // Map the upper seven bits of a byte to a one-hot control vector.
  function automatic logic [NCTRL-1:0] sys_decode(input logic [6:0] hi7);
    logic [NCTRL-1:0] v;
    v = '0;
    if (hi7 == OP_WAKE[7:1])  v[CP_WAKE]  = 1'b1;
    if (hi7 == OP_STBY[7:1])  v[CP_STBY]  = 1'b1;
    if (hi7 == OP_RST[7:1])   v[CP_RST]   = 1'b1;
    if (hi7 == OP_START[7:1]) v[CP_START] = 1'b1;
    if (hi7 == OP_STOP[7:1])  v[CP_STOP]  = 1'b1;
    if (hi7 == OP_OCAL[7:1])  v[CP_OCAL]  = 1'b1;
    if (hi7 == OP_RDATA[7:1]) v[CP_RDATA] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/scd_sync.sv
module scd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/scd_shift.sv
module scd_shift #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          cs_n_s,
  input  logic          mosi_s,
  output logic          fall,
  output logic          edge7,
  output logic          edge8,
  output logic [BW-2:0] hi7,
  output logic [BW-1:0] rx_byte
);
  localparam int CW = $clog2(BW);

  logic          sclk_d;
  logic [BW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  assign fall    = sclk_d & ~sclk_s & ~cs_n_s;
  assign edge7   = fall && (cnt_q == CW'(BW-2));
  assign edge8   = fall && (cnt_q == CW'(BW-1));
  assign hi7     = {sh_q[BW-3:0], mosi_s};
  assign rx_byte = {sh_q[BW-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (cs_n_s) begin
        cnt_q <= '0;
      end else if (fall) begin
        sh_q  <= rx_byte;
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  a_r7_bitcnt_clear: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (cnt_q == '0));
endmodule

// File: rtl/scd_regfile.sv
module scd_regfile #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/scd_fsm.sv
module scd_fsm
  import scd_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_s,
  input  logic             fall,
  input  logic             edge7,
  input  logic             edge8,
  input  logic [DW-2:0]    hi7,
  input  logic [DW-1:0]    rx_byte,
  input  logic [DW-1:0]    rf_q,
  output logic             rf_we,
  output logic [AW-1:0]    rf_addr,
  output logic             miso,
  output logic             miso_oe,
  output logic             cont_mode,
  output logic [NCTRL-1:0] ctrl
);
  scd_state_t       st;
  logic             is_rd;
  logic [AW-1:0]    ptr;
  logic [CNT_W-1:0] rem;
  logic [DW-1:0]    tx;
  logic [NCTRL-1:0] ctrl_d;

  assign ctrl_d  = sys_decode(hi7);
  assign rf_we   = edge8 && (st == ST_WR);
  assign rf_addr = ptr;
  assign miso    = miso_oe & tx[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_CMD;
      is_rd     <= 1'b0;
      ptr       <= '0;
      rem       <= '0;
      tx        <= '0;
      miso_oe   <= 1'b0;
      cont_mode <= 1'b1;
      ctrl      <= '0;
    end else begin
      ctrl <= '0;
      if (cs_n_s) begin
        st      <= ST_CMD;
        miso_oe <= 1'b0;
      end else if (edge7 && st == ST_CMD) begin
        ctrl <= ctrl_d;
        if (ctrl_d[CP_RST]) cont_mode <= 1'b1;
      end else if (edge8) begin
        unique case (st)
          ST_CMD: begin
            if (rx_byte == OP_CONT_ON) begin
              cont_mode <= 1'b1;
            end else if (rx_byte == OP_CONT_OFF) begin
              cont_mode <= 1'b0;
            end else if (!cont_mode && (rx_byte[7:5] == GRP_RREG ||
                                        rx_byte[7:5] == GRP_WREG)) begin
              is_rd <= (rx_byte[7:5] == GRP_RREG);
              ptr   <= rx_byte[AW-1:0];
              st    <= ST_ARG;
            end
          end
          ST_ARG: begin
            rem <= rx_byte[CNT_W-1:0];
            if (is_rd) begin
              tx      <= rf_q;
              ptr     <= ptr + AW'(1);
              miso_oe <= 1'b1;
              st      <= ST_RD;
            end else begin
              st <= ST_WR;
            end
          end
          ST_RD: begin
            if (rem == '0) begin
              st      <= ST_CMD;
              miso_oe <= 1'b0;
            end else begin
              rem <= rem - CNT_W'(1);
              tx  <= rf_q;
              ptr <= ptr + AW'(1);
            end
          end
          ST_WR: begin
            ptr <= ptr + AW'(1);
            if (rem == '0) st <= ST_CMD;
            else rem <= rem - CNT_W'(1);
          end
          default: st <= ST_CMD;
        endcase
      end else if (fall && st == ST_RD) begin
        tx <= {tx[DW-2:0], 1'b0};
      end
    end
  end

  a_r1_onehot_ctrl: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl));
  a_r1_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (|ctrl) |=> !(|ctrl));
  a_r7_cs_abort: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (st == ST_CMD) && !miso_oe);
  a_r5_oe_in_read: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> (st == ST_RD));
  a_r9_cont_blocks_reg: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CMD && cont_mode) |=> (st != ST_ARG));
endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front
  import scd_pkg::*;
#(
  parameter int AW      = 5,
  parameter int DW      = 8,
  parameter int SYNC_FF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe,
  output logic cont_mode,
  output logic wake_p,
  output logic stby_p,
  output logic reset_p,
  output logic start_p,
  output logic stop_p,
  output logic ocal_p,
  output logic rdata_p
);
  logic [2:0]       pins_s;
  logic             sclk_s, cs_n_s, mosi_s;
  logic             fall, edge7, edge8;
  logic [DW-2:0]    hi7;
  logic [DW-1:0]    rx_byte, rf_q;
  logic             rf_we;
  logic [AW-1:0]    rf_addr;
  logic [NCTRL-1:0] ctrl;

  scd_sync #(.WIDTH(3), .STAGES(SYNC_FF), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .din({mosi, cs_n, sclk}), .dout(pins_s));
  assign {mosi_s, cs_n_s, sclk_s} = pins_s;

  scd_shift #(.BW(DW)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .fall(fall), .edge7(edge7), .edge8(edge8), .hi7(hi7), .rx_byte(rx_byte));

  scd_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .fall(fall), .edge7(edge7),
    .edge8(edge8), .hi7(hi7), .rx_byte(rx_byte), .rf_q(rf_q),
    .rf_we(rf_we), .rf_addr(rf_addr), .miso(miso), .miso_oe(miso_oe),
    .cont_mode(cont_mode), .ctrl(ctrl));

  scd_regfile #(.AW(AW), .DW(DW)) u_rf (
    .clk(clk), .we(rf_we), .addr(rf_addr), .wdata(rx_byte), .q(rf_q));

  assign wake_p  = ctrl[CP_WAKE];
  assign stby_p  = ctrl[CP_STBY];
  assign reset_p = ctrl[CP_RST];
  assign start_p = ctrl[CP_START];
  assign stop_p  = ctrl[CP_STOP];
  assign ocal_p  = ctrl[CP_OCAL];
  assign rdata_p = ctrl[CP_RDATA];
endmodule

// File: tb/spi_cmd_front_test.sv
module spi_cmd_front_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, cont_mode;
  logic wake_p, stby_p, reset_p, start_p, stop_p, ocal_p, rdata_p;
  logic [6:0] pv;

  int nchk = 0, nerr = 0;
  int pc [7];
  int mid_pc [7];
  int base [7];
  logic mid_cont;
  logic mid_oe;
  logic [7:0] rbuf [32];
  logic [7:0] junk;

  always #2 clk = ~clk;

  spi_cmd_front uut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .cont_mode(cont_mode),
    .wake_p(wake_p), .stby_p(stby_p), .reset_p(reset_p), .start_p(start_p),
    .stop_p(stop_p), .ocal_p(ocal_p), .rdata_p(rdata_p));

  assign pv = {rdata_p, ocal_p, stop_p, start_p, reset_p, stby_p, wake_p};

  initial for (int k = 0; k < 7; k++) pc[k] = 0;
  always @(posedge clk) for (int k = 0; k < 7; k++) if (pv[k]) pc[k] <= pc[k] + 1;

  // {opcode, expected pulse index (7 = none)}
  localparam logic [11:0] VEC [0:10] = '{
    {8'h02, 4'd0}, {8'h04, 4'd1}, {8'h06, 4'd2}, {8'h08, 4'd3},
    {8'h0A, 4'd4}, {8'h1A, 4'd5}, {8'h12, 4'd6}, {8'h03, 4'd0},
    {8'h1B, 4'd5}, {8'h00, 4'd7}, {8'hFF, 4'd7}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xbyte(input logic [7:0] b, input int nbits, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      sclk = 1'b1;
      wclk(8);
      r[i] = miso;
      sclk = 1'b0;
      wclk(8);
      if (i == 1) begin
        for (int k = 0; k < 7; k++) mid_pc[k] = pc[k];
        mid_cont = cont_mode;
      end
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wclk(8);
  endtask

  task automatic cs_hi();
    wclk(8);
    cs_n = 1'b1;
    wclk(8);
  endtask

  task automatic one_cmd(input logic [7:0] b);
    cs_lo();
    xbyte(b, 8, junk);
    cs_hi();
  endtask

  task automatic snap_base();
    for (int k = 0; k < 7; k++) base[k] = pc[k];
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] n, input logic [7:0] d0);
    cs_lo();
    xbyte(8'h40 | a, 8, junk);
    xbyte(n, 8, junk);
    for (int i = 0; i <= int'(n); i++) xbyte(d0 + 8'(i), 8, junk);
    cs_hi();
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] n);
    cs_lo();
    xbyte(8'h20 | a, 8, junk);
    xbyte(n, 8, junk);
    mid_oe = miso_oe;
    for (int i = 0; i <= int'(n); i++) xbyte(8'h00, 8, rbuf[i]);
    wclk(4);
    chk("R5 miso_oe low after last byte", 32'(miso_oe), 32'd0);
    cs_hi();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    wclk(6);
    rst = 1'b0;
    wclk(4);
    // R3 reset state
    chk("R3 cont_mode after reset", 32'(cont_mode), 32'd1);
    chk("R5 miso_oe after reset", 32'(miso_oe), 32'd0);
    chk("R1 no pulses after reset", 32'(pc[0]+pc[1]+pc[2]+pc[3]+pc[4]+pc[5]+pc[6]), 32'd0);

    // R1 R2 R8 opcode table
    for (int v = 0; v < 11; v++) begin
      logic [7:0] op;
      int ei;
      string tag;
      op = VEC[v][11:4];
      ei = int'(VEC[v][3:0]);
      tag = (ei == 6) ? "R2" : (ei == 7) ? "R8" : "R1";
      snap_base();
      one_cmd(op);
      for (int k = 0; k < 7; k++) begin
        chk({tag, " pulse by 7th edge"}, 32'(mid_pc[k] - base[k]), (k == ei) ? 32'd1 : 32'd0);
        chk({tag, " pulse count after byte"}, 32'(pc[k] - base[k]), (k == ei) ? 32'd1 : 32'd0);
      end
    end
    chk("R8 cont unchanged by table", 32'(cont_mode), 32'd1);

    // R3 leave continuous mode at the eighth edge
    one_cmd(8'h11);
    chk("R3 cont still set at 7th edge", 32'(mid_cont), 32'd1);
    chk("R3 cont cleared by 11h", 32'(cont_mode), 32'd0);

    // R6 single write, then R9 blocked write in continuous mode
    do_write(8'h00, 8'h00, 8'h55);
    one_cmd(8'h10);
    chk("R3 cont set by 10h", 32'(cont_mode), 32'd1);
    snap_base();
    do_write(8'h00, 8'h00, 8'hAA);
    chk("R9 cont unchanged", 32'(cont_mode), 32'd1);
    chk("R9 no pulse from ignored write", 32'(pc[0]+pc[1]+pc[2]+pc[3]+pc[4]+pc[5]+pc[6]
        - base[0]-base[1]-base[2]-base[3]-base[4]-base[5]-base[6]), 32'd0);
    chk("R9 miso_oe idle", 32'(miso_oe), 32'd0);
    one_cmd(8'h11);
    do_read(8'h00, 8'h00);
    chk("R9 reg0 kept 55h", 32'(rbuf[0]), 32'h55);
    chk("R5 miso_oe high in read", 32'(mid_oe), 32'd1);

    // R4 R6 burst with offset start
    do_write(8'h03, 8'h04, 8'hA1);
    do_read(8'h04, 8'h02);
    chk("R4 burst byte0", 32'(rbuf[0]), 32'hA2);
    chk("R4 burst byte1", 32'(rbuf[1]), 32'hA3);
    chk("R6 burst byte2", 32'(rbuf[2]), 32'hA4);
    do_read(8'h03, 8'h00);
    chk("R4 count 0 reads one", 32'(rbuf[0]), 32'hA1);

    // R4 address wrap 31 -> 0
    do_write(8'h1F, 8'h01, 8'hC1);
    do_read(8'h1F, 8'h01);
    chk("R4 wrap reg31", 32'(rbuf[0]), 32'hC1);
    chk("R4 wrap reg0", 32'(rbuf[1]), 32'hC2);

    // R7 abort inside a write data byte
    do_write(8'h02, 8'h00, 8'h77);
    cs_lo();
    xbyte(8'h41, 8, junk);
    xbyte(8'h01, 8, junk);
    xbyte(8'hD0, 8, junk);
    xbyte(8'hE5, 4, junk);
    cs_hi();
    do_read(8'h01, 8'h01);
    chk("R7 complete byte stored", 32'(rbuf[0]), 32'hD0);
    chk("R7 partial byte not stored", 32'(rbuf[1]), 32'h77);

    // R7 abort inside a read
    cs_lo();
    xbyte(8'h20, 8, junk);
    xbyte(8'h02, 8, junk);
    xbyte(8'h00, 3, junk);
    cs_hi();
    chk("R7 miso_oe dropped on abort", 32'(miso_oe), 32'd0);

    // R7 partial command then full opcode: framing restarts
    cs_lo();
    xbyte(8'h00, 6, junk);
    cs_hi();
    snap_base();
    one_cmd(8'h04);
    chk("R7 stby after partial byte", 32'(pc[1] - base[1]), 32'd1);
    chk("R7 no wake after partial byte", 32'(pc[0] - base[0]), 32'd0);

    // R8 unused byte in register mode leaves state
    one_cmd(8'h7F);
    chk("R8 cont unchanged by 7Fh", 32'(cont_mode), 32'd0);
    do_read(8'h00, 8'h00);
    chk("R8 reg0 unchanged", 32'(rbuf[0]), 32'hC2);

    // R3 reset opcode restores continuous mode
    snap_base();
    one_cmd(8'h06);
    chk("R3 reset opcode sets cont", 32'(cont_mode), 32'd1);
    chk("R1 reset pulse", 32'(pc[2] - base[2]), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule